// File: doc/BRIEF.md
# Power-Management Command Port Controller

This block decodes byte writes to a power-management command port. Two reserved command codes turn a firmware-mode flag on and off. This flag is the SCI enable, and it tells the system that the OS owns power events. Every other code is a request for system-management service. Such a code raises an SMI only when an enable bit in a small configuration window is set.

A host writes the command byte at offset 0. It can also write a scratch status byte at offset 1, which the block stores and nothing else. Both bytes read back on a combinational read port. A four-byte configuration window holds the SMI enable bit and has its own write and read port. The SMI request is a level output. It stays high until the system-management side pulses the acknowledge input.

The parameter `SMM_SUPPORT` sets the reset value of the configuration byte that holds the SMI enable bit. When system-management mode is supported, that byte resets to zero and SMIs are off. When it is not supported, the byte resets with the enable bit already set, which marks system-management mode as already initialised.

Top module: `apm_smi_ctrl`

## Requirements
- R1: A write of 0xF1 to the command offset (address 0) sets `sci_en_o` on the next clock edge.
- R2: A write of 0xF0 to the command offset clears `sci_en_o` on the next clock edge.
- R3: Command values 0xF0 and 0xF1 never raise `smi_req_o`, whatever the enable bit holds. Other command values and status writes leave `sci_en_o` unchanged.
- R4: Any other command value sets `smi_req_o` on the next edge when bit 1 of configuration byte 3 is 1. When that bit is 0, the write leaves `smi_req_o` unchanged.
- R5: `smi_req_o` holds high until a cycle with `smi_ack_i` high clears it. The clear takes effect on the next edge. If an SMI-raising write arrives in the same cycle as the acknowledge, the request stays high.
- R6: After reset, `sci_en_o` is 0, `smi_req_o` is 0, and both read-back bytes are 0. Configuration bytes 0 to 2 are 0. With `SMM_SUPPORT`=1, byte 3 is also 0.
- R7: With `SMM_SUPPORT`=0, configuration byte 3 resets to 0x02.
- R8: Reading address 0 returns the last command byte written. Reading address 1 returns the last status byte written. A status write has no effect on `sci_en_o` or `smi_req_o`.
- R9: A configuration write to byte index `cfg_addr_i` stores the data on the next edge, and `cfg_rdata_o` returns it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Host byte write strobe |
| wr_addr_i | input | 1 | Host write offset: 0 is command, 1 is status |
| wr_data_i | input | 8 | Host write data |
| rd_addr_i | input | 1 | Host read offset |
| rd_data_o | output | 8 | Host read data, combinational |
| cfg_we_i | input | 1 | Configuration byte write strobe |
| cfg_addr_i | input | 2 | Configuration byte index |
| cfg_wdata_i | input | 8 | Configuration write data |
| cfg_rdata_o | output | 8 | Configuration byte at `cfg_addr_i` |
| smi_ack_i | input | 1 | SMI acknowledge pulse |
| smi_req_o | output | 1 | SMI request level |
| sci_en_o | output | 1 | ACPI mode (SCI enable) flag |

## Verification
The assertions check on every cycle the one-cycle effect of the two reserved codes on the SCI flag. They also check that those codes never start an SMI, that a gated command raises the request, that the request holds until it is acknowledged, and that the flag stays put without a command write. Only the bench scenarios can show the read-back contents of the command, status and configuration bytes. They also cover the reset value of the enable byte under each `SMM_SUPPORT` setting, and the ordering when a set and an acknowledge land in the same cycle.

// File: rtl/apm_pkg.sv
package apm_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam logic [BYTE_W-1:0] CMD_ACPI_ON  = 8'hF1;
  localparam logic [BYTE_W-1:0] CMD_ACPI_OFF = 8'hF0;

  typedef enum logic {
    OFS_CMD    = 1'b0,
    OFS_STATUS = 1'b1
  } host_ofs_e;

  typedef struct packed {
    logic acpi_on;
    logic acpi_off;
    logic smi_cand;
  } cmd_dec_t;
endpackage

// File: rtl/apm_cmd_decode.sv
module apm_cmd_decode
  import apm_pkg::*;
#(
  parameter logic [BYTE_W-1:0] ON_CODE  = CMD_ACPI_ON,
  parameter logic [BYTE_W-1:0] OFF_CODE = CMD_ACPI_OFF
) (
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  output cmd_dec_t          dec_o
);
  logic cmd_wr;
  assign cmd_wr = wr_en_i && (wr_addr_i == OFS_CMD);

  always_comb begin
    dec_o.acpi_on  = cmd_wr && (wr_data_i == ON_CODE);
    dec_o.acpi_off = cmd_wr && (wr_data_i == OFF_CODE);
    dec_o.smi_cand = cmd_wr && (wr_data_i != ON_CODE) && (wr_data_i != OFF_CODE);
  end
endmodule

// File: rtl/apm_cfg_regs.sv
module apm_cfg_regs
  import apm_pkg::*;
#(
  parameter int unsigned N_BYTES     = 4,
  parameter int unsigned EN_BYTE     = 3,
  parameter int unsigned EN_BIT      = 1,
  parameter bit          SMM_SUPPORT = 1'b1,
  localparam int unsigned AW = (N_BYTES > 1) ? $clog2(N_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              we_i,
  input  logic [AW-1:0]     addr_i,
  input  logic [BYTE_W-1:0] wdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              smi_en_o
);
  logic [BYTE_W-1:0] cfg_q [N_BYTES];

  for (genvar g = 0; g < N_BYTES; g++) begin : g_byte
    localparam logic [BYTE_W-1:0] RST_VAL =
      (!SMM_SUPPORT && (g == EN_BYTE)) ? BYTE_W'(1 << EN_BIT) : '0;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)                                  cfg_q[g] <= RST_VAL;
      else if (we_i && (addr_i == AW'(g)))          cfg_q[g] <= wdata_i;
    end
  end

  assign rdata_o  = cfg_q[addr_i];
  assign smi_en_o = cfg_q[EN_BYTE][EN_BIT];
endmodule

// File: rtl/apm_smi_latch.sv
module apm_smi_latch (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic set_i,
  input  logic ack_i,
  output logic req_o
);
  // set wins over a simultaneous acknowledge
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     req_o <= 1'b0;
    else if (set_i)  req_o <= 1'b1;
    else if (ack_i)  req_o <= 1'b0;
  end
endmodule

// File: rtl/apm_smi_ctrl.sv
module apm_smi_ctrl
  import apm_pkg::*;
#(
  parameter bit          SMM_SUPPORT = 1'b1,
  parameter int unsigned CFG_BYTES   = 4,
  parameter int unsigned EN_BYTE     = 3,
  parameter int unsigned EN_BIT      = 1,
  localparam int unsigned CAW = (CFG_BYTES > 1) ? $clog2(CFG_BYTES) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic              wr_addr_i,
  input  logic [BYTE_W-1:0] wr_data_i,
  input  logic              rd_addr_i,
  output logic [BYTE_W-1:0] rd_data_o,
  input  logic              cfg_we_i,
  input  logic [CAW-1:0]    cfg_addr_i,
  input  logic [BYTE_W-1:0] cfg_wdata_i,
  output logic [BYTE_W-1:0] cfg_rdata_o,
  input  logic              smi_ack_i,
  output logic              smi_req_o,
  output logic              sci_en_o
);
  cmd_dec_t          dec;
  logic              smi_en;
  logic [BYTE_W-1:0] cmd_q, stat_q;

  apm_cmd_decode i_dec (
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .dec_o     (dec)
  );

  apm_cfg_regs #(
    .N_BYTES     (CFG_BYTES),
    .EN_BYTE     (EN_BYTE),
    .EN_BIT      (EN_BIT),
    .SMM_SUPPORT (SMM_SUPPORT)
  ) i_cfg (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .we_i     (cfg_we_i),
    .addr_i   (cfg_addr_i),
    .wdata_i  (cfg_wdata_i),
    .rdata_o  (cfg_rdata_o),
    .smi_en_o (smi_en)
  );

  apm_smi_latch i_smi (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .set_i  (dec.smi_cand && smi_en),
    .ack_i  (smi_ack_i),
    .req_o  (smi_req_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sci_en_o <= 1'b0;
      cmd_q    <= '0;
      stat_q   <= '0;
    end else begin
      if (dec.acpi_on)       sci_en_o <= 1'b1;
      else if (dec.acpi_off) sci_en_o <= 1'b0;
      if (wr_en_i && wr_addr_i == OFS_CMD)    cmd_q  <= wr_data_i;
      if (wr_en_i && wr_addr_i == OFS_STATUS) stat_q <= wr_data_i;
    end
  end

  assign rd_data_o = (rd_addr_i == OFS_CMD) ? cmd_q : stat_q;
endmodule

// File: rtl/apm_smi_ctrl_chk.sv
module apm_smi_ctrl_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       wr_en_i,
  input logic       wr_addr_i,
  input logic [7:0] wr_data_i,
  input logic       smi_ack_i,
  input logic       smi_en,
  input logic       smi_req_o,
  input logic       sci_en_o
);
  logic cmd_wr, reserved, gated;
  assign cmd_wr   = wr_en_i && !wr_addr_i;
  assign reserved = cmd_wr && (wr_data_i == 8'hF1 || wr_data_i == 8'hF0);
  assign gated    = cmd_wr && !reserved;

  // R1
  sci_on_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && wr_data_i == 8'hF1 |=> sci_en_o);
  // R2
  sci_off_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_wr && wr_data_i == 8'hF0 |=> !sci_en_o);
  // R3
  reserved_no_smi_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reserved && !smi_req_o |=> !smi_req_o);
  // R3
  sci_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reserved |=> $stable(sci_en_o));
  // R4
  smi_raise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gated && smi_en |=> smi_req_o);
  // R5
  smi_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_req_o && !smi_ack_i |=> smi_req_o);
  // R5
  smi_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    smi_ack_i && !cmd_wr |=> !smi_req_o);
endmodule

bind apm_smi_ctrl apm_smi_ctrl_chk i_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .wr_en_i   (wr_en_i),
  .wr_addr_i (wr_addr_i),
  .wr_data_i (wr_data_i),
  .smi_ack_i (smi_ack_i),
  .smi_en    (smi_en),
  .smi_req_o (smi_req_o),
  .sci_en_o  (sci_en_o)
);

// File: tb/test_apm_smi_ctrl.sv
module test_apm_smi_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_en = 1'b0, wr_addr = 1'b0, rd_addr = 1'b0;
  logic [7:0] wr_data = '0, cfg_wdata = '0;
  logic cfg_we = 1'b0, smi_ack = 1'b0;
  logic [1:0] cfg_addr = '0;
  logic [7:0] rd_data, cfg_rdata, rd_data_n, cfg_rdata_n;
  logic smi_req, sci_en, smi_req_n, sci_en_n;

  int errors = 0, checks = 0;
  logic       m_sci, m_smi;
  logic [7:0] m_cmd, m_stat;
  logic [7:0] m_cfg [4];

  always #10 clk = ~clk;

  apm_smi_ctrl #(.SMM_SUPPORT(1'b1)) i_apm_smi_ctrl (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata), .smi_ack_i(smi_ack), .smi_req_o(smi_req),
    .sci_en_o(sci_en));

  apm_smi_ctrl #(.SMM_SUPPORT(1'b0)) i_apm_smi_ctrl_nosmm (
    .clk_i(clk), .rst_ni(rst_n), .wr_en_i(wr_en), .wr_addr_i(wr_addr),
    .wr_data_i(wr_data), .rd_addr_i(rd_addr), .rd_data_o(rd_data_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .cfg_rdata_o(cfg_rdata_n), .smi_ack_i(smi_ack), .smi_req_o(smi_req_n),
    .sci_en_o(sci_en_n));

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit is_reserved(logic [7:0] d);
    return d == 8'hF0 || d == 8'hF1;
  endfunction

  // update model with pre-edge inputs
  task automatic model_edge();
    logic set;
    set = wr_en && !wr_addr && !is_reserved(wr_data) && m_cfg[3][1];
    if (set) m_smi = 1'b1;
    else if (smi_ack) m_smi = 1'b0;
    if (wr_en && !wr_addr && wr_data == 8'hF1) m_sci = 1'b1;
    if (wr_en && !wr_addr && wr_data == 8'hF0) m_sci = 1'b0;
    if (wr_en && !wr_addr) m_cmd = wr_data;
    if (wr_en && wr_addr) m_stat = wr_data;
    if (cfg_we) m_cfg[cfg_addr] = cfg_wdata;
  endtask

  task automatic step();
    @(posedge clk);
    model_edge();
    @(negedge clk);
    wr_en = 1'b0; cfg_we = 1'b0; smi_ack = 1'b0;
  endtask

  task automatic check_all(string tag);
    chk({tag, " R1 R2 R3 sci"}, sci_en, m_sci);
    chk({tag, " R4 R5 smi"}, smi_req, m_smi);
    rd_addr = 1'b0; #1 chk({tag, " R8 cmd"}, rd_data, m_cmd);
    rd_addr = 1'b1; #1 chk({tag, " R8 status"}, rd_data, m_stat);
    for (int k = 0; k < 4; k++) begin
      cfg_addr = 2'(k); #1 chk({tag, " R9 cfg"}, cfg_rdata, m_cfg[k]);
    end
  endtask

  task automatic host_wr(logic a, logic [7:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
  endtask

  task automatic cfg_wr(logic [1:0] a, logic [7:0] d);
    cfg_we = 1'b1; cfg_addr = a; cfg_wdata = d;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    m_sci = 0; m_smi = 0; m_cmd = 0; m_stat = 0;
    for (int k = 0; k < 4; k++) m_cfg[k] = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R6 reset state
    check_all("R6 reset");
    // R7 no-SMM variant
    cfg_addr = 2'd3; #1 chk("R7 nosmm cfg3", cfg_rdata_n, 8'h02);
    chk("R7 nosmm smi reset", smi_req_n, 0);
    host_wr(1'b0, 8'h55); step();
    chk("R7 nosmm gated cmd raises smi", smi_req_n, 1);
    chk("R4 smm disabled-bit no smi", smi_req, 0);
    check_all("R4");
    // R1 / R2
    host_wr(1'b0, 8'hF1); step(); chk("R1 sci set", sci_en, 1); check_all("R1");
    host_wr(1'b0, 8'hF0); step(); chk("R2 sci clear", sci_en, 0); check_all("R2");
    // R3 reserved codes with enable set
    cfg_wr(2'd3, 8'h02); step(); check_all("R9");
    host_wr(1'b0, 8'hF1); step(); chk("R3 F1 no smi", smi_req, 0);
    host_wr(1'b0, 8'hF0); step(); chk("R3 F0 no smi", smi_req, 0);
    // R4 raise
    host_wr(1'b0, 8'hB2); step(); chk("R4 smi raised", smi_req, 1);
    chk("R3 sci unchanged by other code", sci_en, 0);
    // R5 hold across idle and new write
    step(); chk("R5 smi held", smi_req, 1);
    host_wr(1'b1, 8'hA5); step(); chk("R8 status no side effect smi", smi_req, 1);
    check_all("R8");
    smi_ack = 1'b1; step(); chk("R5 ack clears", smi_req, 0);
    // R5 set and ack together
    host_wr(1'b0, 8'h10); smi_ack = 1'b1; step(); chk("R5 set beats ack", smi_req, 1);
    smi_ack = 1'b1; step(); chk("R5 ack clears again", smi_req, 0);
    check_all("R5");
    // random
    for (int i = 0; i < 400; i++) begin
      int op;
      op = $urandom_range(0, 5);
      case (op)
        0: host_wr(1'b0, ($urandom_range(0, 1) != 0) ? 8'hF0 + 8'($urandom_range(0, 1))
                                                     : 8'($urandom));
        1: host_wr(1'b0, 8'($urandom));
        2: host_wr(1'b1, 8'($urandom));
        3: cfg_wr(2'($urandom), 8'($urandom));
        4: smi_ack = 1'b1;
        default: ;
      endcase
      if ($urandom_range(0, 3) == 0) smi_ack = 1'b1;
      step();
      check_all("rand");
    end
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule